// File: doc/BRIEF.md
# Three-Byte DAC Command Receiver over I2C

This block is a write-only I2C target for an eight-channel DAC. It watches the SCL and SDA lines, picks out framed write transactions sent to its own 7-bit address, and turns each one into a single command word. Every frame carries three payload bytes. The first byte holds a 4-bit operation code in its high half and a 4-bit channel selector in its low half. The second and third bytes together form a 16-bit sample word sent most significant bit first, with the useful value pushed up against the top.

The `RES` parameter sets the sample width to 12, 10 or 8 bits. The block keeps only that many upper bits of the 16-bit word and drops the padding below them. After a stop condition that closes a frame of exactly three acknowledged bytes, the block raises a one-cycle strobe. The operation code, channel and sample appear on the output ports in that same cycle and stay there until the next strobe. Frames that are broken off, run too long, or are sent to another address leave the outputs unchanged.

The lines are sampled by a fast system clock through a synchroniser. The block pulls SDA low only to acknowledge a byte.

Top module: `dac_cmd_i2c_rx`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `cmd_valid_o` and `sda_pull_o` are 0. `cmd_o`, `chan_o` and `data_o` are 0 after reset.
- R2: When the first byte after a start equals `{DEV_ADDR, 1'b0}`, the block pulls SDA low for the whole ninth SCL high phase. The pull only changes while SCL is low.
- R3: If the address byte names another target, or has its lowest bit set to 1 (a read), the block acknowledges nothing until the next start and emits no strobe.
- R4: In an addressed frame, the block acknowledges each of the first three data bytes in its ninth clock.
- R5: `cmd_o` is bits 7..4 of the first data byte and `chan_o` is bits 3..0 of the first data byte.
- R6: The 16-bit word is byte two followed by byte three. `data_o` is its top `RES` bits, so the bits below position 16-`RES` have no effect on the output.
- R7: A stop that follows exactly three acknowledged data bytes produces a `cmd_valid_o` pulse that lasts exactly one clock cycle. When the pulse occurs, both lines are high.
- R8: A stop after fewer than three data bytes produces no strobe. A repeated start drops the partial frame, and the frame that follows it is handled on its own terms.
- R9: A fourth data byte is not acknowledged, and the frame then produces no strobe.
- R10: `cmd_o`, `chan_o` and `data_o` change only in the cycle in which `cmd_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_pull_o | output | 1 | 1 drives SDA low (acknowledge), 0 releases it |
| cmd_valid_o | output | 1 | One-cycle strobe for a completed command |
| cmd_o | output | 4 | Operation code of the last command |
| chan_o | output | 4 | Channel selector of the last command |
| data_o | output | RES | Sample value of the last command |

## Verification
The assertions assume that SCL stays low for several system clocks after each falling edge, which leaves room for the synchroniser delay before the acknowledge changes. They also assume that SDA moves only while SCL is low, except for start and stop conditions, and that both lines stay high for a few cycles after a stop. The bench models the bus master with a quarter bit period of ten system clocks, so every SCL phase lasts far longer than the three-flop detection delay. It releases SDA with a wired-AND against the target's pull, which lets the bench read acknowledges exactly as a real master would.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

    localparam int BYTE_W      = 8;
    localparam int NIB_W       = 4;
    localparam int WORD_W      = 16;
    localparam int DEV_ADDR_W  = 7;
    localparam int FRAME_BYTES = 3;
    localparam int BIT_CNT_W   = $clog2(BYTE_W + 1);
    localparam int BYTE_CNT_W  = $clog2(FRAME_BYTES + 1);

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_ADDR,
        FR_DATA,
        FR_SKIP
    } frame_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic sda;
    } bus_evt_t;

    typedef struct packed {
        logic [NIB_W-1:0]  op;
        logic [NIB_W-1:0]  chan;
        logic [WORD_W-1:0] word;
    } raw_cmd_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b,
                                      input logic [DEV_ADDR_W-1:0] a);
        return (b[BYTE_W-1:1] == a) && !b[0];
    endfunction

endpackage

// File: rtl/dac_bus_sync.sv
module dac_bus_sync
    import dac_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt_o
);

    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;
    logic scl_s, sda_s;

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    always_comb begin
        evt_o.start    = scl_s & scl_q & sda_q & ~sda_s;
        evt_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
        evt_o.scl_rise = scl_s & ~scl_q;
        evt_o.scl_fall = ~scl_s & scl_q;
        evt_o.sda      = sda_s;
    end

endmodule

// File: rtl/dac_frame_rx.sv
module dac_frame_rx
    import dac_cmd_pkg::*;
#(
    parameter logic [DEV_ADDR_W-1:0] DEV_ADDR = 7'h2A
) (
    input  logic     clk,
    input  logic     rst,
    input  bus_evt_t evt_i,
    output logic     ack_o,
    output logic     done_o,
    output raw_cmd_t raw_o
);

    localparam logic [BIT_CNT_W-1:0]  LAST_BIT  = BIT_CNT_W'(BYTE_W);
    localparam logic [BYTE_CNT_W-1:0] FULL_CNT  = BYTE_CNT_W'(FRAME_BYTES);

    frame_state_e              state;
    logic [BIT_CNT_W-1:0]      bit_cnt;
    logic [BYTE_CNT_W-1:0]     byte_cnt;
    logic [BYTE_W-1:0]         shreg;
    logic                      ack_on;
    logic                      done_q;
    raw_cmd_t                  raw_q;
    logic                      active;

    assign active = (state == FR_ADDR) || (state == FR_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= FR_IDLE;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            shreg    <= '0;
            ack_on   <= 1'b0;
            done_q   <= 1'b0;
            raw_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (evt_i.start) begin
                state    <= FR_ADDR;
                bit_cnt  <= '0;
                byte_cnt <= '0;
                ack_on   <= 1'b0;
            end else if (evt_i.stop) begin
                // the stop's own SCL rise may have clocked in at most one bit
                if (state == FR_DATA && byte_cnt == FULL_CNT && !ack_on &&
                    bit_cnt <= BIT_CNT_W'(1))
                    done_q <= 1'b1;
                state  <= FR_IDLE;
                ack_on <= 1'b0;
            end else if (active) begin
                if (evt_i.scl_rise && !ack_on && bit_cnt < LAST_BIT) begin
                    shreg   <= {shreg[BYTE_W-2:0], evt_i.sda};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (evt_i.scl_fall) begin
                    if (ack_on) begin
                        ack_on  <= 1'b0;
                        bit_cnt <= '0;
                        if (state == FR_ADDR) state <= FR_DATA;
                    end else if (bit_cnt == LAST_BIT) begin
                        if (state == FR_ADDR) begin
                            if (addr_hit(shreg, DEV_ADDR)) ack_on <= 1'b1;
                            else                           state  <= FR_SKIP;
                        end else if (byte_cnt == FULL_CNT) begin
                            state <= FR_SKIP;
                        end else begin
                            ack_on   <= 1'b1;
                            byte_cnt <= byte_cnt + 1'b1;
                            case (byte_cnt)
                                BYTE_CNT_W'(0): begin
                                    raw_q.op   <= shreg[BYTE_W-1:NIB_W];
                                    raw_q.chan <= shreg[NIB_W-1:0];
                                end
                                BYTE_CNT_W'(1): raw_q.word[WORD_W-1:BYTE_W] <= shreg;
                                default:        raw_q.word[BYTE_W-1:0]      <= shreg;
                            endcase
                        end
                    end
                end
            end
        end
    end

    assign ack_o  = ack_on;
    assign done_o = done_q;
    assign raw_o  = raw_q;

endmodule

// File: rtl/dac_word_pick.sv
module dac_word_pick
    import dac_cmd_pkg::*;
#(
    parameter int RES = 12
) (
    input  logic [WORD_W-1:0] word_i,
    output logic [RES-1:0]    value_o
);

    generate
        if (RES == 12 || RES == 10 || RES == 8) begin : g_ok
            assign value_o = word_i[WORD_W-1 -: RES];
        end else begin : g_bad
            $error("dac_word_pick: RES must be 8, 10 or 12");
            assign value_o = '0;
        end
    endgenerate

endmodule

// File: rtl/dac_cmd_i2c_rx.sv
module dac_cmd_i2c_rx
    import dac_cmd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h2A,
    parameter int         RES         = 12,
    parameter int         SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           scl_i,
    input  logic           sda_i,
    output logic           sda_pull_o,
    output logic           cmd_valid_o,
    output logic [3:0]     cmd_o,
    output logic [3:0]     chan_o,
    output logic [RES-1:0] data_o
);

    bus_evt_t       evt;
    raw_cmd_t       raw;
    logic           done;
    logic [RES-1:0] value;

    dac_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt_o (evt)
    );

    dac_frame_rx #(.DEV_ADDR(DEV_ADDR)) frame_i (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt),
        .ack_o  (sda_pull_o),
        .done_o (done),
        .raw_o  (raw)
    );

    dac_word_pick #(.RES(RES)) pick_i (
        .word_i  (raw.word),
        .value_o (value)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid_o <= 1'b0;
            cmd_o       <= '0;
            chan_o      <= '0;
            data_o      <= '0;
        end else begin
            cmd_valid_o <= done;
            if (done) begin
                cmd_o  <= raw.op;
                chan_o <= raw.chan;
                data_o <= value;
            end
        end
    end

endmodule

// File: rtl/dac_cmd_i2c_rx_chk.sv
module dac_cmd_i2c_rx_chk #(
    parameter int RES = 12
) (
    input logic           clk,
    input logic           rst,
    input logic           scl_i,
    input logic           sda_i,
    input logic           sda_pull_o,
    input logic           cmd_valid_o,
    input logic [3:0]     cmd_o,
    input logic [3:0]     chan_o,
    input logic [RES-1:0] data_o
);

    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        $fell(rst) |-> (!cmd_valid_o && !sda_pull_o));

    assert_pull_moves_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_pull_o) |-> !scl_i);

    assert_single_cycle_strobe_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |=> !cmd_valid_o);

    assert_strobe_on_idle_bus_R7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_o |-> (scl_i && sda_i));

    assert_fields_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid_o |-> ($stable(cmd_o) && $stable(chan_o) && $stable(data_o)));

endmodule

bind dac_cmd_i2c_rx dac_cmd_i2c_rx_chk #(.RES(RES)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl_i),
    .sda_i       (sda_i),
    .sda_pull_o  (sda_pull_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_o       (cmd_o),
    .chan_o      (chan_o),
    .data_o      (data_o)
);

// File: tb/dac_cmd_i2c_rx_tb.sv
`timescale 1ns/1ps
module dac_cmd_i2c_rx_tb_top;

    localparam int         RES  = 12;
    localparam logic [6:0] ADDR = 7'h2A;
    localparam int         Q    = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_pull_o, cmd_valid_o;
    logic [3:0] cmd_o, chan_o;
    logic [RES-1:0] data_o;

    int total = 0;
    int bad   = 0;
    int vcount = 0;
    bit finished = 1'b0;

    logic [3:0]     exp_cmd  = '0;
    logic [3:0]     exp_chan = '0;
    logic [RES-1:0] exp_data = '0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull_o;

    dac_cmd_i2c_rx #(.DEV_ADDR(ADDR), .RES(RES)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_pull_o  (sda_pull_o),
        .cmd_valid_o (cmd_valid_o),
        .cmd_o       (cmd_o),
        .chan_o      (chan_o),
        .data_o      (data_o)
    );

    always @(negedge clk) if (!rst && cmd_valid_o) vcount++;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic qwait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; qwait(Q);
        sda_m = 1'b0; qwait(Q);
        scl_m = 1'b0; qwait(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; qwait(Q);
        scl_m = 1'b1; qwait(Q);
        sda_m = 1'b0; qwait(Q);
        scl_m = 1'b0; qwait(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait(Q);
        scl_m = 1'b1; qwait(Q);
        sda_m = 1'b1; qwait(3 * Q);
    endtask

    task automatic bus_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qwait(Q);
            scl_m = 1'b1; qwait(2 * Q);
            scl_m = 1'b0; qwait(Q);
        end
        sda_m = 1'b1; qwait(Q);
        scl_m = 1'b1; qwait(Q);
        acked = !sda_line;
        qwait(Q);
        scl_m = 1'b0; qwait(Q);
    endtask

    // full frame: address byte then n data bytes, stop optional
    task automatic frame(input logic [7:0] a, input logic [7:0] b0,
                         input logic [7:0] b1, input logic [7:0] b2,
                         input logic [7:0] b3, input int n, input bit with_stop,
                         output bit [4:0] acks);
        bit k;
        acks = '0;
        bus_start();
        bus_byte(a, k); acks[0] = k;
        if (n > 0) begin bus_byte(b0, k); acks[1] = k; end
        if (n > 1) begin bus_byte(b1, k); acks[2] = k; end
        if (n > 2) begin bus_byte(b2, k); acks[3] = k; end
        if (n > 3) begin bus_byte(b3, k); acks[4] = k; end
        if (with_stop) bus_stop();
    endtask

    task automatic check_fields(input string req);
        check(cmd_o == exp_cmd,   "R5", {req, " command"}, cmd_o, exp_cmd);
        check(chan_o == exp_chan, "R5", {req, " channel"}, chan_o, exp_chan);
        check(data_o == exp_data, "R6", {req, " data"},    data_o, exp_data);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit [4:0] acks;
        int v0;
        logic [15:0] w;
        logic [7:0] addr_w;
        addr_w = {ADDR, 1'b0};

        qwait(5);
        check(cmd_valid_o == 1'b0, "R1", "strobe in reset", cmd_valid_o, 0);
        check(sda_pull_o == 1'b0,  "R1", "pull in reset",   sda_pull_o, 0);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_valid_o == 1'b0 && sda_pull_o == 1'b0, "R1", "quiet after reset",
              {cmd_valid_o, sda_pull_o}, 0);
        check(data_o == '0 && cmd_o == '0 && chan_o == '0, "R1", "fields after reset",
              data_o, 0);
        qwait(20);

        // R5 R6 R7 R2 R4: sweep of every operation code
        for (int k = 0; k < 16; k++) begin
            w = 16'(k * 4099) ^ 16'hA5C3;
            v0 = vcount;
            frame(addr_w, {4'(k), 4'((k * 7) & 15)}, w[15:8], w[7:0], 8'h00, 3, 1'b1, acks);
            exp_cmd  = 4'(k);
            exp_chan = 4'((k * 7) & 15);
            exp_data = RES'(w >> (16 - RES));
            check(acks[0] == 1'b1, "R2", "address ack", acks[0], 1);
            check(acks[3:1] == 3'b111, "R4", "data acks", acks[3:1], 7);
            check(vcount == v0 + 1, "R7", "one strobe cycle", vcount - v0, 1);
            check_fields("sweep");
        end

        // R6: padding bits below the sample are ignored
        w = 16'h5A3F;
        frame(addr_w, 8'h31, w[15:8], w[7:0], 8'h00, 3, 1'b1, acks);
        frame(addr_w, 8'h31, w[15:8], w[7:0] & 8'hF0, 8'h00, 3, 1'b1, acks);
        exp_cmd = 4'h3; exp_chan = 4'h1; exp_data = RES'(w >> (16 - RES));
        check(data_o == exp_data, "R6", "padding ignored", data_o, exp_data);

        // R3: wrong address
        v0 = vcount;
        frame({ADDR ^ 7'h01, 1'b0}, 8'hFF, 8'hFF, 8'hFF, 8'h00, 3, 1'b1, acks);
        check(acks == 5'b0, "R3", "no ack for other address", acks, 0);
        check(vcount == v0, "R3", "no strobe for other address", vcount - v0, 0);
        check_fields("R10 hold after foreign frame");

        // R3: read bit
        v0 = vcount;
        frame({ADDR, 1'b1}, 8'hEE, 8'hEE, 8'hEE, 8'h00, 3, 1'b1, acks);
        check(acks == 5'b0, "R3", "no ack for read", acks, 0);
        check(vcount == v0, "R3", "no strobe for read", vcount - v0, 0);

        // R8: short frame
        v0 = vcount;
        frame(addr_w, 8'h77, 8'h12, 8'h00, 8'h00, 2, 1'b1, acks);
        check(vcount == v0, "R8", "no strobe for short frame", vcount - v0, 0);
        check_fields("R10 hold after short frame");

        // R8: repeated start after two bytes, then a full frame
        v0 = vcount;
        frame(addr_w, 8'h99, 8'hAB, 8'h00, 8'h00, 2, 1'b0, acks);
        bus_rstart();
        begin
            bit k2;
            bus_byte(addr_w, k2);
            bus_byte(8'hC6, k2);
            bus_byte(8'h80, k2);
            bus_byte(8'h1F, k2);
            bus_stop();
        end
        exp_cmd = 4'hC; exp_chan = 4'h6; exp_data = RES'(16'h801F >> (16 - RES));
        check(vcount == v0 + 1, "R8", "one strobe after repeated start", vcount - v0, 1);
        check_fields("R8 after repeated start");

        // R9: four data bytes
        v0 = vcount;
        frame(addr_w, 8'h25, 8'h44, 8'h55, 8'h66, 4, 1'b1, acks);
        check(acks[3:0] == 4'b1111, "R4", "first three acked", acks[3:0], 15);
        check(acks[4] == 1'b0, "R9", "fourth byte not acked", acks[4], 0);
        check(vcount == v0, "R9", "no strobe for long frame", vcount - v0, 0);
        check_fields("R10 hold after long frame");

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule